// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Line Takeover

This block takes fire events from a set of comparator channels and turns each one into an interrupt. A fire can drive one of 32 interrupt lines, either as a held level or as a one-clock pulse. It can instead be sent as a single 32-bit message write on a valid/ready port. Every channel has a status bit, and software clears that bit by writing a 1 to it. The channel settings are the enable, the trigger type, the line index and the message enable. They arrive as static inputs, together with a global enable and a legacy-takeover flag. The comparators and the register bus sit outside this block.

When legacy takeover is on, channel 0 always drives line 0 and channel 1 always drives line 8. The two external legacy inputs, the interval-timer interrupt and the real-time-clock interrupt, are cut off from those lines. The `pit_en_o` output goes low so that the interval timer can be shut off. The real-time-clock level is sampled on every cycle, even during takeover, so line 8 shows its current value again as soon as takeover ends.

The state updates on the clock edge that samples a fire. The line outputs are combinational from that registered state, so a fire shows on the lines in the cycle after the edge.

Top module: `tir_router`

## Requirements
- R1: A fire on an enabled level-type channel that is not in message mode sets its status bit. It holds the channel's target line high until the status bit is cleared.
- R2: A fire on an enabled edge-type channel clears its status bit. It raises the target line for exactly one clock cycle.
- R3: A 1 in bit t of `sts_clr_i` clears status bit t and releases the line that the bit was holding. A 0 bit leaves the status unchanged. If a fire and a clear hit the same channel in the same cycle, the fire wins.
- R4: While a channel is disabled or `glb_en_i` is low, that channel's status bit reads 0. The channel then drives no line and has no pending message.
- R5: Outside legacy takeover, channel t targets the line whose index is `ch_route_i[t*5 +: 5]`.
- R6: In legacy takeover, channel 0 targets line 0 and channel 1 targets line 8, whatever their route fields say. Channels 2 and above still follow their route fields.
- R7: A fire on an enabled channel with message mode on produces one transfer. The transfer carries `msg_addr_i[t*32 +: 32]` as its address and `msg_data_i[t*32 +: 32]` as its data. It drives no line and leaves the status bit unchanged.
- R8: `msg_valid_o`, `msg_addr_o` and `msg_data_o` stay stable until `msg_ready_i` is seen high. When several channels have messages pending, the lowest channel index goes first.
- R9: `pit_en_o` is high out of reset and whenever takeover is off. It is low from the cycle after takeover is set.
- R10: Outside takeover, `ext_pit_irq_i` drives line 0 and `ext_rtc_irq_i` drives line 8, each one cycle after it is sampled. During takeover neither input affects those lines. The clock input is still sampled, so on leaving takeover line 8 shows its current level.
- R11: After reset the status bits are 0, every line is low and `msg_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_en_i | input | 1 | Legacy line takeover |
| fire_i | input | NUM_TMR | One-cycle fire event from each channel |
| ch_en_i | input | NUM_TMR | Per-channel enable |
| ch_level_i | input | NUM_TMR | 1 = level type, 0 = edge type |
| ch_msg_en_i | input | NUM_TMR | Per-channel message-mode enable |
| ch_route_i | input | NUM_TMR*5 | Target line index for each channel |
| msg_addr_i | input | NUM_TMR*32 | Message address for each channel |
| msg_data_i | input | NUM_TMR*32 | Message data for each channel |
| sts_clr_i | input | NUM_TMR | Write-1-to-clear strobe for the status bits |
| ext_pit_irq_i | input | 1 | External interval-timer interrupt |
| ext_rtc_irq_i | input | 1 | External real-time-clock interrupt level |
| msg_ready_i | input | 1 | Message sink ready |
| irq_o | output | 32 | Interrupt lines |
| sts_o | output | NUM_TMR | Per-channel status bits |
| pit_en_o | output | 1 | Enable for the legacy interval timer |
| msg_valid_o | output | 1 | Message transfer valid |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The assertions assume that `fire_i` is a one-cycle event. They also assume that the per-channel address and data inputs stay constant while that channel's message is pending. The address and data are captured when the message is granted, so a change after that point is never visible. The bench drives every input on the falling edge and holds the channel settings constant during each scenario. It changes the route, the trigger type and the message fields only while the affected channel is idle.

// File: rtl/tir_pkg.sv
package tir_pkg;
  localparam int unsigned NUM_LINES    = 32;
  localparam int unsigned ROUTE_W      = $clog2(NUM_LINES);
  localparam int unsigned MSG_W        = 32;
  localparam int unsigned LEG_PIT_LINE = 0;
  localparam int unsigned LEG_RTC_LINE = 8;
  typedef logic [MSG_W-1:0]     word_t;
  typedef logic [ROUTE_W-1:0]   route_t;
  typedef logic [NUM_LINES-1:0] lines_t;
endpackage

// File: rtl/tir_chan.sv
module tir_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic level_i,
  input  logic msg_en_i,
  input  logic fire_i,
  input  logic clr_i,
  input  logic grant_i,
  output logic sts_o,
  output logic pend_o,
  output logic drive_o
);
  logic sts_q, pulse_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pulse_q <= en_i && fire_i && !msg_en_i && !level_i;
      if (!en_i)                       sts_q <= 1'b0;
      else if (fire_i && !msg_en_i)    sts_q <= level_i;
      else if (clr_i)                  sts_q <= 1'b0;
      if (!en_i || !msg_en_i)          pend_q <= 1'b0;
      else if (fire_i)                 pend_q <= 1'b1;
      else if (grant_i)                pend_q <= 1'b0;
    end
  end

  assign sts_o   = sts_q;
  assign pend_o  = pend_q;
  assign drive_o = !msg_en_i && ((level_i && sts_q) || pulse_q);

  // R4
  sts_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!sts_q && !pend_q));
  // R3
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fire_i) |=> !sts_q);
  // R2
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && !fire_i) |=> !pulse_q);
endmodule

// File: rtl/tir_msg_arb.sv
module tir_msg_arb
  import tir_pkg::*;
#(
  parameter int unsigned NUM_TMR = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_TMR-1:0]       pend_i,
  input  logic [NUM_TMR*MSG_W-1:0] addr_i,
  input  logic [NUM_TMR*MSG_W-1:0] data_i,
  input  logic                     ready_i,
  output logic [NUM_TMR-1:0]       grant_o,
  output logic                     valid_o,
  output word_t                    addr_o,
  output word_t                    data_o
);
  logic  valid_q, take;
  word_t addr_q, data_q, addr_sel, data_sel;

  assign take    = !valid_q || ready_i;
  assign grant_o = take ? (pend_i & (~pend_i + 1'b1)) : '0;

  always_comb begin
    addr_sel = '0;
    data_sel = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (grant_o[t]) begin
        addr_sel = addr_sel | addr_i[t*MSG_W +: MSG_W];
        data_sel = data_sel | data_i[t*MSG_W +: MSG_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (take) begin
      valid_q <= |pend_i;
      if (|pend_i) begin
        addr_q <= addr_sel;
        data_q <= data_sel;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  // R8
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> (valid_q && $stable(addr_q) && $stable(data_q)));
  // R8
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));
endmodule

// File: rtl/tir_line_map.sv
module tir_line_map
  import tir_pkg::*;
#(
  parameter int unsigned NUM_TMR = 4
) (
  input  logic                       legacy_i,
  input  logic [NUM_TMR-1:0]         drive_i,
  input  logic [NUM_TMR*ROUTE_W-1:0] route_i,
  input  logic                       pit_lvl_i,
  input  logic                       rtc_lvl_i,
  output lines_t                     irq_o
);
  route_t tgt [NUM_TMR];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tgt
    if (t == 0) begin : g_t0
      assign tgt[t] = legacy_i ? route_t'(LEG_PIT_LINE) : route_i[t*ROUTE_W +: ROUTE_W];
    end else if (t == 1) begin : g_t1
      assign tgt[t] = legacy_i ? route_t'(LEG_RTC_LINE) : route_i[t*ROUTE_W +: ROUTE_W];
    end else begin : g_tn
      assign tgt[t] = route_i[t*ROUTE_W +: ROUTE_W];
    end
  end

  always_comb begin
    irq_o = '0;
    for (int t = 0; t < NUM_TMR; t++) begin
      if (drive_i[t]) irq_o[tgt[t]] = 1'b1;
    end
    if (!legacy_i) begin
      irq_o[LEG_PIT_LINE] = irq_o[LEG_PIT_LINE] | pit_lvl_i;
      irq_o[LEG_RTC_LINE] = irq_o[LEG_RTC_LINE] | rtc_lvl_i;
    end
  end
endmodule

// File: rtl/tir_router.sv
module tir_router
  import tir_pkg::*;
#(
  parameter int unsigned NUM_TMR = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       glb_en_i,
  input  logic                       legacy_en_i,
  input  logic [NUM_TMR-1:0]         fire_i,
  input  logic [NUM_TMR-1:0]         ch_en_i,
  input  logic [NUM_TMR-1:0]         ch_level_i,
  input  logic [NUM_TMR-1:0]         ch_msg_en_i,
  input  logic [NUM_TMR*ROUTE_W-1:0] ch_route_i,
  input  logic [NUM_TMR*MSG_W-1:0]   msg_addr_i,
  input  logic [NUM_TMR*MSG_W-1:0]   msg_data_i,
  input  logic [NUM_TMR-1:0]         sts_clr_i,
  input  logic                       ext_pit_irq_i,
  input  logic                       ext_rtc_irq_i,
  input  logic                       msg_ready_i,
  output logic [NUM_LINES-1:0]       irq_o,
  output logic [NUM_TMR-1:0]         sts_o,
  output logic                       pit_en_o,
  output logic                       msg_valid_o,
  output logic [MSG_W-1:0]           msg_addr_o,
  output logic [MSG_W-1:0]           msg_data_o
);
  logic               legacy_q, pit_q, rtc_q;
  logic [NUM_TMR-1:0] pend, grant, drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      legacy_q <= 1'b0;
      pit_q    <= 1'b0;
      rtc_q    <= 1'b0;
    end else begin
      legacy_q <= legacy_en_i;
      pit_q    <= ext_pit_irq_i;
      rtc_q    <= ext_rtc_irq_i;  // recorded in every mode
    end
  end

  assign pit_en_o = !legacy_q;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_ch
    tir_chan u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (ch_en_i[t] && glb_en_i),
      .level_i (ch_level_i[t]),
      .msg_en_i(ch_msg_en_i[t]),
      .fire_i  (fire_i[t]),
      .clr_i   (sts_clr_i[t]),
      .grant_i (grant[t]),
      .sts_o   (sts_o[t]),
      .pend_o  (pend[t]),
      .drive_o (drive[t])
    );
  end

  tir_msg_arb #(.NUM_TMR(NUM_TMR)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pend_i (pend),
    .addr_i (msg_addr_i),
    .data_i (msg_data_i),
    .ready_i(msg_ready_i),
    .grant_o(grant),
    .valid_o(msg_valid_o),
    .addr_o (msg_addr_o),
    .data_o (msg_data_o)
  );

  tir_line_map #(.NUM_TMR(NUM_TMR)) u_map (
    .legacy_i (legacy_q),
    .drive_i  (drive),
    .route_i  (ch_route_i),
    .pit_lvl_i(pit_q),
    .rtc_lvl_i(rtc_q),
    .irq_o    (irq_o)
  );

  // R10
  legacy_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_q && !drive[0] && !drive[1]) |-> (!irq_o[LEG_PIT_LINE] || (|drive)));
endmodule

// File: tb/tb_tir_router.sv
module tb_tir_router;
  localparam int N  = 4;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glb_en = 1'b0, legacy = 1'b0;
  logic [N-1:0]  fire = '0, ch_en = '0, ch_level = '0, ch_msg = '0, clr = '0;
  logic [N*RW-1:0] route = '0;
  logic [N*32-1:0] maddr = '0, mdata = '0;
  logic          ext_pit = 1'b0, ext_rtc = 1'b0, ready = 1'b0;
  logic [31:0]   irq;
  logic [N-1:0]  sts;
  logic          pit_en, mvalid;
  logic [31:0]   maddr_o, mdata_o;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  tir_router #(.NUM_TMR(N)) dut (
    .clk_i(clk), .rst_ni(rst_n), .glb_en_i(glb_en), .legacy_en_i(legacy),
    .fire_i(fire), .ch_en_i(ch_en), .ch_level_i(ch_level), .ch_msg_en_i(ch_msg),
    .ch_route_i(route), .msg_addr_i(maddr), .msg_data_i(mdata), .sts_clr_i(clr),
    .ext_pit_irq_i(ext_pit), .ext_rtc_irq_i(ext_rtc), .msg_ready_i(ready),
    .irq_o(irq), .sts_o(sts), .pit_en_o(pit_en), .msg_valid_o(mvalid),
    .msg_addr_o(maddr_o), .msg_data_o(mdata_o)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fire_one(input int t);
    fire[t] = 1'b1;
    step();
    fire[t] = 1'b0;
  endtask

  task automatic clear_bits(input logic [N-1:0] m);
    clr = m;
    step();
    clr = '0;
  endtask

  task automatic t_reset();
    chk(sts, 0, "R11 status");
    chk(irq, 0, "R11 lines");
    chk(mvalid, 0, "R11 msg valid");
    chk(pit_en, 1, "R9 pit enable at reset");
  endtask

  task automatic t_level();
    glb_en = 1'b1;
    ch_en[2] = 1'b1; ch_level[2] = 1'b1; route[2*RW +: RW] = 5'd5;
    fire_one(2);
    chk(sts[2], 1, "R1 status set");
    chk(irq, 32'h1 << 5, "R5 R1 line 5 high");
    step(); step();
    chk(irq, 32'h1 << 5, "R1 line held");
    clear_bits(4'b1011);
    chk(sts[2], 1, "R3 zero bit no effect");
    chk(irq, 32'h1 << 5, "R3 line kept");
    clear_bits(4'b0100);
    chk(sts[2], 0, "R3 status cleared");
    chk(irq, 0, "R3 line lowered");
    fire[2] = 1'b1; clr[2] = 1'b1;
    step();
    fire[2] = 1'b0; clr[2] = 1'b0;
    chk(sts[2], 1, "R3 fire beats clear");
    clear_bits(4'b0100);
  endtask

  task automatic t_edge();
    ch_en[3] = 1'b1; ch_level[3] = 1'b0; route[3*RW +: RW] = 5'd12;
    fire_one(3);
    chk(irq, 32'h1 << 12, "R2 pulse high");
    chk(sts[3], 0, "R2 status clear");
    step();
    chk(irq, 0, "R2 pulse one clock");
  endtask

  task automatic t_disable();
    ch_en[2] = 1'b0;
    fire_one(2);
    chk(sts[2], 0, "R4 disabled channel status");
    chk(irq, 0, "R4 disabled channel line");
    ch_en[2] = 1'b1;
    fire_one(2);
    chk(sts[2], 1, "R4 setup");
    glb_en = 1'b0;
    step();
    chk(sts[2], 0, "R4 global disable clears");
    chk(irq, 0, "R4 global disable lowers");
    glb_en = 1'b1;
    step();
    chk(sts[2], 0, "R4 stays clear");
  endtask

  task automatic wait_valid(input string req);
    for (int i = 0; i < 5 && !mvalid; i++) step();
    chk(mvalid, 1, req);
  endtask

  task automatic t_msg();
    ch_en[1:0] = 2'b11; ch_msg[1:0] = 2'b11; ch_level[1:0] = 2'b11;
    maddr[0 +: 32] = 32'hFEE0_0000; mdata[0 +: 32] = 32'h0000_0041;
    maddr[32 +: 32] = 32'hFEE0_1000; mdata[32 +: 32] = 32'h0000_0052;
    fire_one(1);
    wait_valid("R7 message issued");
    chk(maddr_o, 32'hFEE0_1000, "R7 address");
    chk(mdata_o, 32'h0000_0052, "R7 data");
    chk(irq, 0, "R7 no line");
    chk(sts[1], 0, "R7 status unchanged");
    step(); step();
    chk({mvalid, maddr_o}, {1'b1, 32'hFEE0_1000}, "R8 held without ready");
    ready = 1'b1;
    step();
    ready = 1'b0;
    chk(mvalid, 0, "R8 single transfer");
    fire[0] = 1'b1; fire[1] = 1'b1;
    step();
    fire = '0;
    wait_valid("R8 two pending");
    chk(maddr_o, 32'hFEE0_0000, "R8 lowest first");
    ready = 1'b1;
    step();
    chk({mvalid, maddr_o, mdata_o}, {1'b1, 32'hFEE0_1000, 32'h0000_0052}, "R8 second");
    step();
    chk(mvalid, 0, "R8 drained");
    ready = 1'b0;
    ch_msg = '0; ch_en[1:0] = 2'b00;
  endtask

  task automatic t_legacy();
    ext_pit = 1'b1; ext_rtc = 1'b1;
    step();
    chk(irq, 32'h101, "R10 external pass");
    legacy = 1'b1;
    step();
    chk(pit_en, 0, "R9 pit disabled");
    chk(irq, 0, "R10 external muted");
    ext_rtc = 1'b0; step();
    ext_rtc = 1'b1; step();
    chk(irq, 0, "R10 rtc muted in takeover");
    ch_en[0] = 1'b1; ch_level[0] = 1'b1; route[0 +: RW] = 5'd20;
    fire_one(0);
    chk(irq, 32'h1, "R6 timer0 to line 0");
    clear_bits(4'b0001);
    ch_en[1] = 1'b1; ch_level[1] = 1'b0; route[RW +: RW] = 5'd3;
    fire_one(1);
    chk(irq, 32'h1 << 8, "R6 timer1 to line 8");
    step();
    fire_one(2);
    chk(irq, 32'h1 << 5, "R6 timer2 keeps route");
    clear_bits(4'b0100);
    fire_one(1);
    legacy = 1'b0;
    chk(irq, 32'h1 << 8, "R6 pulse before exit");
    step();
    chk(pit_en, 1, "R9 pit re-enabled");
    chk(irq, 32'h101, "R10 rtc level restored");
    fire_one(0);
    chk(irq, 32'h101 | (32'h1 << 20), "R5 timer0 back on route");
    clear_bits(4'b0001);
    ext_pit = 1'b0; ext_rtc = 1'b0;
    step();
    chk(irq, 0, "R10 external low");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_disable();
    t_msg();
    t_legacy();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule